// File: doc/BRIEF.md
# ACPI Power Rail Sequencer

This block is the digital supervisor for a memory and core-logic power subsystem. It takes the two active-low sleep requests from the platform, a standby-supply-good flag and a 12 V-good flag, and drives enable lines for five rails: memory VDDQ, memory VTT, the upper and lower stages of a two-stage core LDO, and a termination LDO. Each rail reports back through a digital "in regulation" input. The analog loops, comparators and ramp generators sit outside the block.

Leaving a sleep state starts the same sequence every time. The block holds the PWM error amplifier in reset for a fixed number of soft-start periods and then brings the rails up in a set order. Each later rail waits until the rails that feed it report that they regulate. The power-good output is armed a set number of soft-start periods after VTT is enabled. Once armed, it follows the termination rail. VDDQ stays up through S3, so a return from S3 leaves it running. A shutdown request from the fault supervisor turns every rail off and holds them off until the platform passes through S5. The soft-start period arrives as a one-clock tick from an external generator. A test setup can therefore shorten it without changing this block.

Top module: `acpi_rail_sequencer`

## Requirements
- R1: While rstN is low or sbyGood is low, every rail enable, ampReset and pgood are 0 and vttTieRef is 1.
- R2: With slpS5N and slpS3N high but p12Good low, no rail is enabled and ampReset stays 0.
- R3: When both sleep inputs and p12Good are high, ampReset rises one clock later. It stays high through RST_PERIODS (default 3) ssTick pulses with no rail enabled. One clock after the last of those ticks, enVddq and enCoreUp are 1 and ampReset is 0.
- R4: enCoreLo rises only one clock after vddqOk and coreUpOk are both high. enTerm rises one clock after coreOk is high. enVtt rises one clock after termOk is high.
- R5: pgood stays 0 after enVtt rises until PG_PERIODS (default 1) ssTick pulses have passed. After that, pgood equals termOk in the same cycle.
- R6: One clock after slpS3N goes low with slpS5N high, every enable except enVddq is 0 and pgood is 0. enVddq keeps its value.
- R7: vttTieRef is 1 whenever enVtt is 0 and 0 whenever enVtt is 1.
- R8: On a return from S3, the block waits for p12Good, runs the R3 amplifier reset and then the R4 order. enVddq stays 1 throughout.
- R9: One clock after slpS5N is low, from any state, all enables and pgood are 0.
- R10: One clock after shutReq is high, all enables and pgood are 0. They stay 0, whatever the other inputs do, until slpS5N has been low.
- R11: Losing p12Good while active has the effect of S3 entry (R6). When p12Good returns, the R8 sequence runs.
- R12: pgood is 0 in every state other than fully active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sbyGood | input | 1 | Standby bias supply above its power-on threshold |
| p12Good | input | 1 | 12 V supply above its power-on threshold |
| slpS3N | input | 1 | Active-low S3 sleep request |
| slpS5N | input | 1 | Active-low S5 sleep request |
| ssTick | input | 1 | One-clock pulse marking the end of each soft-start period |
| shutReq | input | 1 | Fault supervisor request for a latched shutdown |
| vddqOk | input | 1 | VDDQ in regulation |
| coreUpOk | input | 1 | Upper core LDO in regulation |
| coreOk | input | 1 | Core rail (lower LDO) in regulation |
| termOk | input | 1 | Termination LDO in regulation |
| enVddq | output | 1 | VDDQ switcher enable |
| enCoreUp | output | 1 | Upper core LDO enable |
| enCoreLo | output | 1 | Lower core LDO enable |
| enTerm | output | 1 | Termination LDO enable |
| enVtt | output | 1 | Memory VTT regulator enable |
| vttTieRef | output | 1 | Tie VTT reference to its output so that VTT floats |
| ampReset | output | 1 | Error-amplifier reset strobe |
| pgood | output | 1 | Power-good (1 = released) |

## Verification
The hardest case to reach is a return from S3, where VDDQ must stay up while every other rail goes through the full reset and ramp again. The bench first drives the block to full activity. It then lowers slpS3N and withdraws the downstream regulation flags while keeping vddqOk high. It also drops p12Good so that the block has to wait. It then restores the inputs one at a time and checks enVddq at each stage. The latched shutdown gets the same treatment: the bench keeps every other input at its active value while ticks continue, and checks that nothing restarts until slpS5N is pulsed.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  typedef enum logic [3:0] {
    ST_OFF, ST_SLEEP, ST_LOCK, ST_AMPRST,
    ST_RAMPA, ST_RAMPB, ST_RAMPC, ST_RAMPD, ST_ACTIVE
  } seqState_t;

  // Strobes from the control FSM to the rail datapath
  typedef struct packed {
    logic clrAll;      // drop every rail and disarm power-good
    logic clrKeepVddq; // drop every rail but VDDQ, disarm power-good
    logic setA;        // VDDQ and upper core LDO
    logic setB;        // lower core LDO
    logic setC;        // termination LDO
    logic setD;        // memory VTT
    logic armPg;       // arm power-good comparator
    logic cntClr;      // restart period counter
    logic ampOn;       // amplifier reset level for next cycle
  } seqStrobe_t;

  localparam int NUM_RAILS = 5;
  localparam int RAIL_VDDQ = 0;
  localparam int RAIL_CUP  = 1;
  localparam int RAIL_CLO  = 2;
  localparam int RAIL_TERM = 3;
  localparam int RAIL_VTT  = 4;

endpackage

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rail_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sbyGood,
  input  logic       p12Good,
  input  logic       slpS3N,
  input  logic       slpS5N,
  input  logic       shutReq,
  input  logic       vddqOk,
  input  logic       coreUpOk,
  input  logic       coreOk,
  input  logic       termOk,
  input  logic       rstDone,
  input  logic       pgDone,
  output seqStrobe_t strb
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    if (!sbyGood || !slpS5N) begin
      nextState   = ST_OFF;
      strb.clrAll = 1'b1;
    end else if (shutReq || state == ST_LOCK) begin
      nextState   = ST_LOCK;
      strb.clrAll = 1'b1;
    end else if (!slpS3N || !p12Good) begin
      nextState        = (state == ST_OFF) ? ST_OFF : ST_SLEEP;
      strb.clrKeepVddq = 1'b1;
    end else begin
      unique case (state)
        ST_OFF, ST_SLEEP, ST_LOCK: begin
          nextState   = ST_AMPRST;
          strb.cntClr = 1'b1;
        end
        ST_AMPRST: if (rstDone) begin
          nextState   = ST_RAMPA;
          strb.setA   = 1'b1;
          strb.cntClr = 1'b1;
        end
        ST_RAMPA: if (vddqOk && coreUpOk) begin
          nextState = ST_RAMPB;
          strb.setB = 1'b1;
        end
        ST_RAMPB: if (coreOk) begin
          nextState = ST_RAMPC;
          strb.setC = 1'b1;
        end
        ST_RAMPC: if (termOk) begin
          nextState   = ST_RAMPD;
          strb.setD   = 1'b1;
          strb.cntClr = 1'b1;
        end
        ST_RAMPD: if (pgDone) begin
          nextState  = ST_ACTIVE;
          strb.armPg = 1'b1;
        end
        ST_ACTIVE: nextState = ST_ACTIVE;
        default:   nextState = ST_OFF;
      endcase
    end
    strb.ampOn = (nextState == ST_AMPRST);
  end

endmodule

// File: rtl/rail_seq_datapath.sv
module rail_seq_datapath
  import rail_seq_pkg::*;
#(
  parameter int RST_PERIODS = 3,
  parameter int PG_PERIODS  = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ssTick,
  input  logic       termOk,
  input  seqStrobe_t strb,
  output logic       rstDone,
  output logic       pgDone,
  output logic [NUM_RAILS-1:0] railEn,
  output logic       ampReset,
  output logic       pgood
);

  localparam int MAX_PERIODS = (RST_PERIODS > PG_PERIODS) ? RST_PERIODS : PG_PERIODS;
  localparam int CNT_W       = $clog2(MAX_PERIODS + 1);
  localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(MAX_PERIODS);
  localparam logic [CNT_W-1:0] RST_LAST  = CNT_W'(RST_PERIODS - 1);
  localparam logic [CNT_W-1:0] PG_LAST   = CNT_W'(PG_PERIODS - 1);

  logic [CNT_W-1:0]     periodCnt;
  logic [NUM_RAILS-1:0] setMask, clrMask;
  logic                 pgArm;

  // Period counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                periodCnt <= '0;
    else if (strb.cntClr)                     periodCnt <= '0;
    else if (ssTick && periodCnt != CNT_SAT)  periodCnt <= periodCnt + 1'b1;
  end

  assign rstDone = ssTick && (periodCnt == RST_LAST);
  assign pgDone  = ssTick && (periodCnt == PG_LAST);

  always_comb begin
    setMask = '0;
    setMask[RAIL_VDDQ] = strb.setA;
    setMask[RAIL_CUP]  = strb.setA;
    setMask[RAIL_CLO]  = strb.setB;
    setMask[RAIL_TERM] = strb.setC;
    setMask[RAIL_VTT]  = strb.setD;
    clrMask = {NUM_RAILS{strb.clrAll | strb.clrKeepVddq}};
    clrMask[RAIL_VDDQ] = strb.clrAll;
  end

  for (genvar i = 0; i < NUM_RAILS; i++) begin : gRail
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           railEn[i] <= 1'b0;
      else if (clrMask[i]) railEn[i] <= 1'b0;
      else if (setMask[i]) railEn[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pgArm    <= 1'b0;
      ampReset <= 1'b0;
    end else begin
      ampReset <= strb.ampOn;
      if (strb.clrAll || strb.clrKeepVddq) pgArm <= 1'b0;
      else if (strb.armPg)                 pgArm <= 1'b1;
    end
  end

  assign pgood = pgArm & termOk;

endmodule

// File: rtl/acpi_rail_sequencer.sv
module acpi_rail_sequencer
  import rail_seq_pkg::*;
#(
  parameter int RST_PERIODS = 3,
  parameter int PG_PERIODS  = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic sbyGood,
  input  logic p12Good,
  input  logic slpS3N,
  input  logic slpS5N,
  input  logic ssTick,
  input  logic shutReq,
  input  logic vddqOk,
  input  logic coreUpOk,
  input  logic coreOk,
  input  logic termOk,
  output logic enVddq,
  output logic enCoreUp,
  output logic enCoreLo,
  output logic enTerm,
  output logic enVtt,
  output logic vttTieRef,
  output logic ampReset,
  output logic pgood
);

  seqStrobe_t           strb;
  logic                 rstDone, pgDone;
  logic [NUM_RAILS-1:0] railEn;

  rail_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sbyGood(sbyGood), .p12Good(p12Good),
    .slpS3N(slpS3N), .slpS5N(slpS5N), .shutReq(shutReq),
    .vddqOk(vddqOk), .coreUpOk(coreUpOk), .coreOk(coreOk), .termOk(termOk),
    .rstDone(rstDone), .pgDone(pgDone), .strb(strb)
  );

  rail_seq_datapath #(.RST_PERIODS(RST_PERIODS), .PG_PERIODS(PG_PERIODS)) u_dp (
    .clk(clk), .rstN(rstN), .ssTick(ssTick), .termOk(termOk), .strb(strb),
    .rstDone(rstDone), .pgDone(pgDone), .railEn(railEn),
    .ampReset(ampReset), .pgood(pgood)
  );

  assign enVddq    = railEn[RAIL_VDDQ];
  assign enCoreUp  = railEn[RAIL_CUP];
  assign enCoreLo  = railEn[RAIL_CLO];
  assign enTerm    = railEn[RAIL_TERM];
  assign enVtt     = railEn[RAIL_VTT];
  assign vttTieRef = ~railEn[RAIL_VTT];

endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk (
  input logic clk,
  input logic rstN,
  input logic sbyGood,
  input logic slpS3N,
  input logic slpS5N,
  input logic shutReq,
  input logic vddqOk,
  input logic coreUpOk,
  input logic coreOk,
  input logic termOk,
  input logic enCoreUp,
  input logic enCoreLo,
  input logic enTerm,
  input logic enVtt,
  input logic enVddq,
  input logic ampReset,
  input logic pgood
);

  // R3
  amp_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ampReset |-> !(enCoreUp || enCoreLo || enTerm || enVtt));

  // R4
  lo_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enCoreLo) |-> $past(vddqOk && coreUpOk));

  // R4
  term_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enTerm) |-> $past(coreOk));

  // R4
  vtt_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enVtt) |-> $past(termOk));

  // R12
  pg_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    pgood |-> (termOk && enVtt && enTerm && enCoreLo && enVddq));

  // R6
  sleep_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sbyGood && slpS5N && !slpS3N) |=> !(enCoreUp || enCoreLo || enTerm || enVtt || pgood));

  // R9
  s5_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !slpS5N |=> !(enVddq || enCoreUp || enCoreLo || enTerm || enVtt || pgood));

  // R10
  lock_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shutReq && slpS5N) |=> !(enVddq || enCoreUp || enCoreLo || enTerm || enVtt || ampReset));

endmodule

bind acpi_rail_sequencer rail_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .sbyGood(sbyGood), .slpS3N(slpS3N), .slpS5N(slpS5N),
  .shutReq(shutReq), .vddqOk(vddqOk), .coreUpOk(coreUpOk), .coreOk(coreOk),
  .termOk(termOk), .enCoreUp(enCoreUp), .enCoreLo(enCoreLo), .enTerm(enTerm),
  .enVtt(enVtt), .enVddq(enVddq), .ampReset(ampReset), .pgood(pgood)
);

// File: tb/sim_acpi_rail_sequencer.sv
module sim_acpi_rail_sequencer;

  logic clk = 1'b0;
  logic rstN = 1'b0, sbyGood = 1'b0, p12Good = 1'b0, slpS3N = 1'b0, slpS5N = 1'b0;
  logic ssTick = 1'b0, shutReq = 1'b0;
  logic vddqOk = 1'b0, coreUpOk = 1'b0, coreOk = 1'b0, termOk = 1'b0;
  logic enVddq, enCoreUp, enCoreLo, enTerm, enVtt, vttTieRef, ampReset, pgood;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  acpi_rail_sequencer u0 (
    .clk(clk), .rstN(rstN), .sbyGood(sbyGood), .p12Good(p12Good),
    .slpS3N(slpS3N), .slpS5N(slpS5N), .ssTick(ssTick), .shutReq(shutReq),
    .vddqOk(vddqOk), .coreUpOk(coreUpOk), .coreOk(coreOk), .termOk(termOk),
    .enVddq(enVddq), .enCoreUp(enCoreUp), .enCoreLo(enCoreLo), .enTerm(enTerm),
    .enVtt(enVtt), .vttTieRef(vttTieRef), .ampReset(ampReset), .pgood(pgood)
  );

  // Order: vddq, coreUp, coreLo, term, vtt, tieRef, ampReset, pgood
  function automatic logic [7:0] outVec();
    return {enVddq, enCoreUp, enCoreLo, enTerm, enVtt, vttTieRef, ampReset, pgood};
  endfunction

  task automatic chk(input string tag, input logic [7:0] expv);
    logic [7:0] act;
    act = outVec();
    nChecks++;
    if (act !== expv) begin
      nFails++;
      $display("FAIL %s: outputs actual %b expected %b at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    ssTick = 1'b1;
    @(negedge clk);
    ssTick = 1'b0;
  endtask

  // From amplifier reset with every regulation flag high: reach active
  task automatic finishBringUp(input string tag);
    tick(); tick(); tick();
    step(3);
    tick();
    chk(tag, 8'b11111001);
  endtask

  task automatic tReset();
    step(2);
    chk("R1 reset", 8'b00000100);
    rstN = 1'b1; sbyGood = 1'b1;
    step(2);
    chk("R1 idle after reset", 8'b00000100);
  endtask

  task automatic tColdStart();
    slpS5N = 1'b1; slpS3N = 1'b1;
    step(3);
    chk("R2 no 12V", 8'b00000100);
    p12Good = 1'b1;
    step(1);
    chk("R3 amp reset on", 8'b00000110);
    tick(); tick();
    chk("R3 amp reset two ticks", 8'b00000110);
    tick();
    chk("R3 first rails", 8'b11000100);
    vddqOk = 1'b1;
    step(2);
    chk("R4 wait upper core", 8'b11000100);
    coreUpOk = 1'b1;
    step(1);
    chk("R4 lower core on", 8'b11100100);
    coreOk = 1'b1;
    step(1);
    chk("R4 term on", 8'b11110100);
    termOk = 1'b1;
    step(1);
    chk("R4 R7 vtt on", 8'b11111000);
    step(2);
    chk("R5 pgood not armed", 8'b11111000);
    tick();
    chk("R5 pgood armed", 8'b11111001);
    #1 termOk = 1'b0;
    #1 chk("R5 pgood follows termOk", 8'b11111000);
    termOk = 1'b1;
    #1 chk("R5 pgood back", 8'b11111001);
  endtask

  task automatic tSleepS3();
    step(1);
    slpS3N = 1'b0; coreUpOk = 1'b0; coreOk = 1'b0; termOk = 1'b0;
    step(1);
    chk("R6 R12 S3 entry", 8'b10000100);
    p12Good = 1'b0;
    step(2);
    chk("R6 S3 hold", 8'b10000100);
  endtask

  task automatic tResume();
    slpS3N = 1'b1;
    step(3);
    chk("R8 wait 12V", 8'b10000100);
    p12Good = 1'b1;
    step(1);
    chk("R8 amp reset vddq kept", 8'b10000110);
    tick(); tick(); tick();
    chk("R8 first rails", 8'b11000100);
    coreUpOk = 1'b1;
    step(1);
    chk("R8 lower core on", 8'b11100100);
    coreOk = 1'b1; termOk = 1'b1;
    step(2);
    chk("R8 R7 vtt on", 8'b11111000);
    tick();
    chk("R8 active", 8'b11111001);
  endtask

  task automatic tP12Loss();
    p12Good = 1'b0;
    step(1);
    chk("R11 12V lost", 8'b10000100);
    p12Good = 1'b1;
    step(1);
    chk("R11 restart", 8'b10000110);
    finishBringUp("R11 active again");
  endtask

  task automatic tS5();
    slpS5N = 1'b0;
    step(1);
    chk("R9 S5 from active", 8'b00000100);
    slpS5N = 1'b1;
    step(1);
    chk("R9 leave S5", 8'b00000110);
    slpS5N = 1'b0;
    step(1);
    chk("R9 S5 during amp reset", 8'b00000100);
    slpS5N = 1'b1;
    step(1);
    finishBringUp("R9 active again");
  endtask

  task automatic tShutdown();
    shutReq = 1'b1;
    step(1);
    shutReq = 1'b0;
    chk("R10 shutdown", 8'b00000100);
    tick();
    step(4);
    chk("R10 stays locked", 8'b00000100);
    slpS5N = 1'b0;
    step(1);
    slpS5N = 1'b1;
    step(1);
    chk("R10 unlock via S5", 8'b00000110);
    finishBringUp("R10 active again");
  endtask

  task automatic tStandbyLoss();
    sbyGood = 1'b0;
    step(1);
    chk("R1 standby lost", 8'b00000100);
  endtask

  initial begin
    step(1);
    tReset();
    tColdStart();
    tSleepS3();
    tResume();
    tP12Loss();
    tS5();
    tShutdown();
    tStandbyLoss();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule